// File: doc/BRIEF.md
# Multi-Format Stereo Audio Serial Port

This block is a slave serial audio port for a stereo converter. An external master supplies the bit clock and the frame clock. The port deserialises left and right samples arriving on a serial input line and delivers them as a pair of parallel words with a one-cycle strobe. It also serialises a pair of parallel transmit words onto a serial output line. All three serial lines are brought into the system clock domain through a synchroniser. The block works on the edges of the bit clock that it detects in that domain.

A two-bit format code selects the receive framing and the transmit framing together. Receive can be right-justified with a 24-bit or a 16-bit word, left-justified, or I2S. Transmit is left-justified unless I2S is selected. A frame may hold 48 or 64 bit clocks. Serial data always travels MSB first as two's complement. Transmit words are captured once per frame, at the start of the left slot, so both channels of one outgoing frame come from the same sample instant.

Top module: `aud_serial_port`

## Requirements
- R1: With format code 00, the receive word is the last 24 bits sampled before a frame-clock edge, with the LSB immediately before the edge. Transmit is 24-bit left-justified.
- R2: With format code 01, the receive word is the last 16 bits before the frame-clock edge, sign-extended to 24 bits. Earlier bits in that half-frame are ignored. Transmit stays 24-bit left-justified.
- R3: With format code 10, both directions are left-justified. The MSB is the first bit sampled after the frame-clock edge, and 24 bits are taken.
- R4: With format code 11, both directions use I2S framing. The MSB falls one bit clock after the frame-clock edge, and the left channel is carried while the frame clock is low.
- R5: In the three justified formats, the left channel is carried while the frame clock is high.
- R6: Frames of 48 and of 64 bit clocks both work. In every format, after a 24-bit transmit word's LSB, the serial output drives 0 until the next slot starts.
- R7: The serial output changes only after a detected falling bit-clock edge, so it is steady across each rising edge, where received data is sampled.
- R8: Both transmit words are latched at the start of the left slot. A change on the transmit inputs later in the frame first appears in the next frame.
- R9: rx_valid pulses high for exactly one clock once per frame, after the right word has completed. rx_left and rx_right change only in that cycle, and every complete frame yields one pulse.
- R10: While in reset and right after it, ser_out, rx_valid, rx_left and rx_right are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fmt_code | input | 2 | Framing select, static outside reset |
| bit_clk | input | 1 | Serial bit clock from the master |
| frm_clk | input | 1 | Frame (channel select) clock from the master |
| ser_in | input | 1 | Serial receive data |
| ser_out | output | 1 | Serial transmit data |
| tx_left | input | 24 | Left transmit word |
| tx_right | input | 24 | Right transmit word |
| rx_left | output | 24 | Last received left word |
| rx_right | output | 24 | Last received right word |
| rx_valid | output | 1 | One-cycle strobe for a new receive pair |

## Verification
The bench builds the port with its default parameters. These are 24-bit words, a 16-bit narrow receive word, half-frames of up to 32 bit clocks, a two-stage synchroniser and sign extension of narrow words. This setting reaches both frame lengths in all four format codes. With it, 48-bit frames exercise the I2S case where the LSB spills into the next half-frame, and 64-bit frames exercise the padding that must be ignored on receive and zero-filled on transmit. The zero-fill variant for narrow words is built only when elaboration selects it, and this bench does not check it.

// File: rtl/asp_pkg.sv
package asp_pkg;

  typedef struct packed {
    logic rx_rjust;   // receive word ends at the frame edge
    logic rx_narrow;  // receive word is the short width
    logic i2s;        // one bit delay, left slot while frame clock low
  } fmt_t;

  function automatic fmt_t decode_fmt(input logic [1:0] code);
    fmt_t f;
    f.rx_rjust  = ~code[1];
    f.rx_narrow = ~code[1] & code[0];
    f.i2s       = code[1] & code[0];
    return f;
  endfunction

endpackage

// File: rtl/asp_sync.sv
module asp_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stg_q;
  logic [STAGES-1:0][WIDTH-1:0] stg_d;

  always_comb begin
    stg_d[0] = d;
    for (int s = 1; s < STAGES; s++) begin
      stg_d[s] = stg_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/asp_edge.sv
module asp_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise,
  output logic fall
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;

endmodule

// File: rtl/asp_rx.sv
module asp_rx
  import asp_pkg::*;
#(
  parameter int DATA_W   = 24,
  parameter int NARROW_W = 16,
  parameter int MAX_HALF = 32,
  parameter bit SIGN_EXT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_en,
  input  logic              frm,
  input  logic              dat,
  input  fmt_t              fmt,
  output logic [DATA_W-1:0] word_left,
  output logic [DATA_W-1:0] word_right,
  output logic              word_valid
);

  localparam int CNT_W = $clog2(MAX_HALF + 1);
  localparam int PAD_W = DATA_W - NARROW_W;
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(MAX_HALF);
  localparam logic [CNT_W-1:0] WIN_LEN = CNT_W'(DATA_W);

  logic              frm_d1_q, frm_d1_d;
  logic              frm_d2_q, frm_d2_d;
  logic              armed_q, armed_d;
  logic              left_ok_q, left_ok_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] shreg_q, shreg_d;
  logic [DATA_W-1:0] hold_q, hold_d;
  logic [DATA_W-1:0] left_q, left_d;
  logic [DATA_W-1:0] right_q, right_d;
  logic              valid_q, valid_d;

  logic              eff_now, eff_prev, slot_edge, left_lvl;
  logic [DATA_W-1:0] narrow_word, done_word;

  generate
    if (SIGN_EXT) begin : g_sext
      assign narrow_word = {{PAD_W{shreg_q[NARROW_W-1]}}, shreg_q[NARROW_W-1:0]};
    end else begin : g_zfill
      assign narrow_word = {shreg_q[NARROW_W-1:0], {PAD_W{1'b0}}};
    end
  endgenerate

  assign eff_now   = fmt.i2s ? frm_d1_q : frm;
  assign eff_prev  = fmt.i2s ? frm_d2_q : frm_d1_q;
  assign slot_edge = eff_now ^ eff_prev;
  assign left_lvl  = ~fmt.i2s;
  assign done_word = fmt.rx_narrow ? narrow_word : shreg_q;

  always_comb begin
    frm_d1_d  = frm_d1_q;
    frm_d2_d  = frm_d2_q;
    armed_d   = armed_q;
    left_ok_d = left_ok_q;
    cnt_d     = cnt_q;
    shreg_d   = shreg_q;
    hold_d    = hold_q;
    left_d    = left_q;
    right_d   = right_q;
    valid_d   = 1'b0;
    if (sample_en) begin
      frm_d1_d = frm;
      frm_d2_d = frm_d1_q;
      if (slot_edge) begin
        armed_d = 1'b1;
        cnt_d   = CNT_W'(1);
        shreg_d = fmt.rx_rjust ? {shreg_q[DATA_W-2:0], dat}
                               : {{(DATA_W-1){1'b0}}, dat};
        if (armed_q) begin
          if (eff_prev == left_lvl) begin
            hold_d    = done_word;
            left_ok_d = 1'b1;
          end else if (left_ok_q) begin
            left_d    = hold_q;
            right_d   = done_word;
            valid_d   = 1'b1;
            left_ok_d = 1'b0;
          end
        end
      end else begin
        if (cnt_q != CNT_TOP) cnt_d = cnt_q + CNT_W'(1);
        if (fmt.rx_rjust || (cnt_q < WIN_LEN)) begin
          shreg_d = {shreg_q[DATA_W-2:0], dat};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_d1_q  <= 1'b0;
      frm_d2_q  <= 1'b0;
      armed_q   <= 1'b0;
      left_ok_q <= 1'b0;
      cnt_q     <= '0;
      shreg_q   <= '0;
      hold_q    <= '0;
      left_q    <= '0;
      right_q   <= '0;
      valid_q   <= 1'b0;
    end else begin
      frm_d1_q  <= frm_d1_d;
      frm_d2_q  <= frm_d2_d;
      armed_q   <= armed_d;
      left_ok_q <= left_ok_d;
      cnt_q     <= cnt_d;
      shreg_q   <= shreg_d;
      hold_q    <= hold_d;
      left_q    <= left_d;
      right_q   <= right_d;
      valid_q   <= valid_d;
    end
  end

  assign word_left  = left_q;
  assign word_right = right_q;
  assign word_valid = valid_q;

endmodule

// File: rtl/asp_tx.sv
module asp_tx #(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              frm,
  input  logic              i2s,
  input  logic [DATA_W-1:0] word_left,
  input  logic [DATA_W-1:0] word_right,
  output logic              ser
);

  logic              frm_d1_q, frm_d1_d;
  logic              frm_d2_q, frm_d2_d;
  logic [DATA_W-1:0] hold_r_q, hold_r_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              out_q, out_d;

  logic              eff_now, eff_prev, slot_edge, left_slot;
  logic [DATA_W-1:0] load_word;

  assign eff_now   = i2s ? frm_d1_q : frm;
  assign eff_prev  = i2s ? frm_d2_q : frm_d1_q;
  assign slot_edge = eff_now ^ eff_prev;
  assign left_slot = (eff_now == ~i2s);
  assign load_word = left_slot ? word_left : hold_r_q;

  always_comb begin
    frm_d1_d = frm_d1_q;
    frm_d2_d = frm_d2_q;
    hold_r_d = hold_r_q;
    sh_d     = sh_q;
    out_d    = out_q;
    if (shift_en) begin
      frm_d1_d = frm;
      frm_d2_d = frm_d1_q;
      if (slot_edge) begin
        if (left_slot) hold_r_d = word_right;
        out_d = load_word[DATA_W-1];
        sh_d  = {load_word[DATA_W-2:0], 1'b0};
      end else begin
        out_d = sh_q[DATA_W-1];
        sh_d  = {sh_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_d1_q <= 1'b0;
      frm_d2_q <= 1'b0;
      hold_r_q <= '0;
      sh_q     <= '0;
      out_q    <= 1'b0;
    end else begin
      frm_d1_q <= frm_d1_d;
      frm_d2_q <= frm_d2_d;
      hold_r_q <= hold_r_d;
      sh_q     <= sh_d;
      out_q    <= out_d;
    end
  end

  assign ser = out_q;

endmodule

// File: rtl/aud_serial_port.sv
module aud_serial_port
  import asp_pkg::*;
#(
  parameter int DATA_W      = 24,
  parameter int NARROW_W    = 16,
  parameter int MAX_HALF    = 32,
  parameter int SYNC_STAGES = 2,
  parameter bit SIGN_EXT    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        fmt_code,
  input  logic              bit_clk,
  input  logic              frm_clk,
  input  logic              ser_in,
  output logic              ser_out,
  input  logic [DATA_W-1:0] tx_left,
  input  logic [DATA_W-1:0] tx_right,
  output logic [DATA_W-1:0] rx_left,
  output logic [DATA_W-1:0] rx_right,
  output logic              rx_valid
);

  localparam int LINES = 3;

  logic [1:0]       rst_pipe_q;
  logic             rst_n_s;
  logic [LINES-1:0] line_raw, line_s;
  logic             bclk_rise, bclk_fall;
  fmt_t             fmt_dec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  assign fmt_dec  = decode_fmt(fmt_code);
  assign line_raw = {bit_clk, frm_clk, ser_in};

  asp_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .d     (line_raw),
    .q     (line_s)
  );

  asp_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n_s),
    .lvl   (line_s[2]),
    .rise  (bclk_rise),
    .fall  (bclk_fall)
  );

  asp_rx #(
    .DATA_W   (DATA_W),
    .NARROW_W (NARROW_W),
    .MAX_HALF (MAX_HALF),
    .SIGN_EXT (SIGN_EXT)
  ) u_rx (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .sample_en  (bclk_rise),
    .frm        (line_s[1]),
    .dat        (line_s[0]),
    .fmt        (fmt_dec),
    .word_left  (rx_left),
    .word_right (rx_right),
    .word_valid (rx_valid)
  );

  asp_tx #(.DATA_W(DATA_W)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .shift_en   (bclk_fall),
    .frm        (line_s[1]),
    .i2s        (fmt_dec.i2s),
    .word_left  (tx_left),
    .word_right (tx_right),
    .ser        (ser_out)
  );

endmodule

// File: rtl/asp_chk.sv
module asp_chk #(
  parameter int DATA_W   = 24,
  parameter int NARROW_W = 16,
  parameter bit SIGN_EXT = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        fmt_code,
  input logic              fall_pulse,
  input logic              ser_out,
  input logic [DATA_W-1:0] rx_left,
  input logic [DATA_W-1:0] rx_right,
  input logic              rx_valid
);

  localparam int TOP_BITS = DATA_W - NARROW_W + 1;

  // R9
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R9
  rx_left_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_left) |-> rx_valid);

  // R9
  rx_right_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_right) |-> rx_valid);

  // R7
  ser_out_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ser_out) |-> $past(fall_pulse));

  generate
    if (SIGN_EXT) begin : g_sext_chk
      // R2
      narrow_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && fmt_code == 2'b01) |->
          (($countones(rx_left[DATA_W-1:NARROW_W-1]) == 0) ||
           ($countones(rx_left[DATA_W-1:NARROW_W-1]) == TOP_BITS)) &&
          (($countones(rx_right[DATA_W-1:NARROW_W-1]) == 0) ||
           ($countones(rx_right[DATA_W-1:NARROW_W-1]) == TOP_BITS)));
    end
  endgenerate

endmodule

bind aud_serial_port asp_chk #(
  .DATA_W   (DATA_W),
  .NARROW_W (NARROW_W),
  .SIGN_EXT (SIGN_EXT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fmt_code   (fmt_code),
  .fall_pulse (bclk_fall),
  .ser_out    (ser_out),
  .rx_left    (rx_left),
  .rx_right   (rx_right),
  .rx_valid   (rx_valid)
);

// File: tb/aud_serial_port_tb.sv
module aud_serial_port_tb;

  localparam int HB   = 6;   // clk cycles per bit-clock phase
  localparam int IDLE = 4;
  localparam int TAIL = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  fmt_code;
  logic        bit_clk, frm_clk, ser_in, ser_out;
  logic [23:0] tx_left, tx_right, rx_left, rx_right;
  logic        rx_valid;

  int    n_chk = 0;
  int    n_bad = 0;
  string rx_tag = "R1 R5";
  logic [47:0] exp_q[$];

  always #10 clk = ~clk;

  aud_serial_port u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .fmt_code (fmt_code),
    .bit_clk  (bit_clk),
    .frm_clk  (frm_clk),
    .ser_in   (ser_in),
    .ser_out  (ser_out),
    .tx_left  (tx_left),
    .tx_right (tx_right),
    .rx_left  (rx_left),
    .rx_right (rx_right),
    .rx_valid (rx_valid)
  );

  task automatic check(input bit ok, input string tag, input logic [47:0] act,
                       input logic [47:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // receive model: each strobe must deliver the next expected pair (R9, R5)
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 strobe without frame", {rx_left, rx_right}, 48'h0);
      end else begin
        logic [47:0] e;
        e = exp_q.pop_front();
        check({rx_left, rx_right} === e, rx_tag, {rx_left, rx_right}, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R9 watchdog actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  task automatic do_reset(input logic [1:0] f);
    rst_n    = 1'b0;
    bit_clk  = 1'b0;
    frm_clk  = 1'b0;
    ser_in   = 1'b0;
    fmt_code = f;
    tx_left  = '0;
    tx_right = '0;
    exp_q.delete();
    repeat (5) @(negedge clk);
    check({ser_out, rx_valid, rx_left, rx_right} === '0, "R10 in reset",
          {23'b0, ser_out, rx_valid, rx_left}, 48'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({ser_out, rx_valid, rx_left, rx_right} === '0, "R10 after reset",
          {23'b0, ser_out, rx_valid, rx_left}, 48'h0);
  endtask

  task automatic run(input int fmt, input int bpf, input int nfr);
    int    half  = bpf / 2;
    bit    i2s   = (fmt == 3);
    bit    lft   = !i2s;
    int    fend  = IDLE + nfr * bpf;
    int    total = fend + TAIL;
    string tt;
    logic [23:0] rl[], rr[], tl[], tr[];
    bit al_rx[], al_tx[], lf[], ld[], et[], ck[];
    rl = new[nfr]; rr = new[nfr]; tl = new[nfr+1]; tr = new[nfr+1];
    al_rx = new[total]; al_tx = new[total]; lf = new[total];
    ld = new[total]; et = new[total]; ck = new[total];
    case (fmt)
      0: begin tt = "R1 R6 R8"; rx_tag = "R1 R5 R6"; end
      1: begin tt = "R2 R6 R8"; rx_tag = "R2 R5 R6"; end
      2: begin tt = "R3 R6 R8"; rx_tag = "R3 R5 R6"; end
      default: begin tt = "R4 R6 R8"; rx_tag = "R4 R6"; end
    endcase
    for (int f = 0; f <= nfr; f++) begin
      tl[f] = 24'($urandom);
      tr[f] = 24'($urandom);
      if (f < nfr) begin
        rl[f] = (f == 0) ? 24'h800000 : (f == 1) ? 24'h7FFFFF : 24'($urandom);
        rr[f] = (f == 0) ? 24'h7FFFFF : (f == 1) ? 24'h00C0A5 : 24'($urandom);
      end
    end
    tl[0] = 24'h800001;
    tr[0] = 24'h7FFFFE;
    for (int k = 0; k < total; k++) begin
      al_rx[k] = 1'b1;
      al_tx[k] = 1'b0;
      if (k < IDLE) lf[k] = !lft;
      else if (k >= fend) lf[k] = lft;
      else begin
        int idx = k - IDLE;
        int f   = idx / bpf;
        int h   = (idx % bpf) / half;
        int i   = idx % half;
        logic [23:0] w, t;
        lf[k] = (h == 0) ? lft : !lft;
        w = (h == 0) ? rl[f] : rr[f];
        t = (h == 0) ? tl[f] : tr[f];
        if (fmt == 0)      al_rx[k] = (i >= half - 24) ? w[half-1-i] : 1'b1;
        else if (fmt == 1) al_rx[k] = (i >= half - 16) ? w[half-1-i] : 1'b1;
        else               al_rx[k] = (i < 24) ? w[23-i] : 1'b1;
        al_tx[k] = (i < 24) ? t[23-i] : 1'b0;
      end
    end
    for (int k = 0; k < total; k++) begin
      ld[k] = i2s ? ((k == 0) ? 1'b1 : al_rx[k-1]) : al_rx[k];
      et[k] = i2s ? ((k == 0) ? 1'b0 : al_tx[k-1]) : al_tx[k];
      ck[k] = i2s ? (k > IDLE && k <= fend) : (k >= IDLE && k < fend);
    end
    for (int f = 0; f < nfr; f++) begin
      logic [23:0] xl, xr;
      xl = (fmt == 1) ? {{8{rl[f][15]}}, rl[f][15:0]} : rl[f];
      xr = (fmt == 1) ? {{8{rr[f][15]}}, rr[f][15:0]} : rr[f];
      exp_q.push_back({xl, xr});
    end
    tx_left  = tl[0];
    tx_right = tr[0];
    for (int k = 0; k < total; k++) begin
      logic seen;
      @(negedge clk);
      bit_clk = 1'b0;
      frm_clk = lf[k];
      ser_in  = ld[k];
      if (k >= IDLE && k < fend && ((k - IDLE) % bpf) == 3) begin
        tx_left  = tl[(k - IDLE) / bpf + 1];
        tx_right = tr[(k - IDLE) / bpf + 1];
      end
      repeat (HB - 1) @(negedge clk);
      seen = ser_out;
      if (ck[k]) check(ser_out === et[k], tt, {47'b0, ser_out}, {47'b0, et[k]});
      @(negedge clk);
      bit_clk = 1'b1;
      repeat (HB - 1) @(negedge clk);
      if (ck[k]) check(ser_out === seen, "R7 held over rising edge",
                       {47'b0, ser_out}, {47'b0, seen});
    end
    @(negedge clk);
    bit_clk = 1'b0;
    repeat (30) @(negedge clk);
    check(exp_q.size() == 0, "R9 one strobe per frame",
          48'(exp_q.size()), 48'h0);
  endtask

  initial begin
    rst_n    = 1'b0;
    bit_clk  = 1'b0;
    frm_clk  = 1'b0;
    ser_in   = 1'b0;
    fmt_code = 2'b00;
    tx_left  = '0;
    tx_right = '0;
    for (int fm = 0; fm < 4; fm++) begin
      for (int b = 0; b < 2; b++) begin
        do_reset(2'(fm));
        run(fm, (b == 0) ? 48 : 64, 4);
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule